// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-bus slave front end for a serial flash command set. It receives chip select, serial clock, serial data in and a hold line, and oversamples them on the system clock. SPI modes 0 and 3 are both accepted. Every frame begins with an 8-bit opcode, sent MSB first. The decoded opcode sets how many address bytes and dummy bytes follow it. After that header, the block does one of two things:

- For read-type opcodes, it shifts result bytes out on the serial output.
- For program, erase and protection opcodes, it forwards each completed data byte to the blocks downstream.

Read traffic uses an auto-incrementing address. That address runs through the whole array and wraps from the top to zero without a gap. Address bits above the array size are dropped. The storage array is not part of this block. It is reached through a byte read port that is combinational on the address. Status, identification and sector-protection values arrive as plain inputs.

A frame ends when chip select rises. For a forwarded command, a completion strobe is raised only if the header was complete and the frame ended on a byte boundary. Unknown opcodes and truncated frames leave no trace. While hold is active, the serial clock and data are ignored and the output is released.

Top module: `sfe_cmd_front`

## Requirements
- R1: After reset, so_oe_o, wr_vld_o and cmd_done_o are all 0.
- R2: Opcode 03h takes three address bytes. Its data bytes are then the memory bytes at that address and the following addresses, each shifted out MSB first. Each output bit changes after a falling SCK edge.
- R3: Opcode 0Bh takes three address bytes and one ignored dummy byte. After that it returns the same stream as 03h.
- R4: The read address is the low 20 bits of the 24-bit address. Reading past 0FFFFFh continues at 000000h with no extra clocks.
- R5: Opcode 05h returns status_i, repeated for every byte clocked.
- R6: Opcode 9Fh returns the bytes of id_i, most significant byte first. It restarts at that byte after the last one.
- R7: Opcode 3Ch takes three address bytes and repeatedly returns FFh if prot_i[address bits 19:16] is 1, otherwise 00h.
- R8: Several opcodes are forwarded. 02h, 20h, 52h, D8h, 36h and 39h take three address bytes. 06h, 04h, 60h, C7h and 01h take none. For all of them, each complete byte after the header pulses wr_vld_o for one cycle with the byte on wr_byte_o, and SO stays released.
- R9: A forwarded frame pulses cmd_done_o for one cycle when chip select rises, with opcode_o and cmd_addr_o holding the opcode and address. This happens only if the header was complete and a whole number of bytes was sent.
- R10: An unknown opcode produces no wr_vld_o, no cmd_done_o and no drive on SO until the next frame.
- R11: so_oe_o is 0 while chip select is high and while hold is active.
- R12: While hold is active, SCK and SI edges are ignored. After hold is released, the frame resumes where it was paused.
- R13: A frame with SCK idling high (mode 3) gives the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (0 = high impedance) |
| mem_addr_o | output | AW | Array read address and current command address |
| mem_data_i | input | 8 | Array byte at mem_addr_o |
| status_i | input | 8 | Status byte |
| id_i | input | 8*ID_BYTES | Identification bytes |
| prot_i | input | SECTORS | Per-sector protection flags |
| opcode_o | output | 8 | Opcode of the current or last frame |
| cmd_addr_o | output | AW | Address of the forwarded command |
| wr_vld_o | output | 1 | Forwarded data byte strobe |
| wr_byte_o | output | 8 | Forwarded data byte |
| cmd_done_o | output | 1 | Forwarded frame completed cleanly |

## Verification
The bench targets several corner cases, each tied to a typical design error:

- **Address wrap.** It reads across the top of the array with the upper address nibble set. A counter that carries into the dropped bits, or that stalls at the boundary, returns the wrong bytes.
- **Hold mid-read.** It asserts hold during a read and toggles SCK meanwhile. A design that counted those edges skips or corrupts bits, and one that kept driving SO is caught by the released enable.
- **Truncated frames.** It ends frames with a short header or a partial data byte. A design that did not check frame alignment raises a false completion.
- **Unknown opcodes and the dummy byte.** It sends an unknown opcode followed by bytes that look like a valid command, and it reads in both clock polarities. A decoder that leaks through, or that mishandles the dummy byte, is exposed.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_READ, K_STAT, K_ID, K_PROT, K_PASS
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] n_addr;
    logic       n_dummy;
  } dec_t;

  function automatic dec_t decode(input logic [7:0] op);
    dec_t d;
    d = '{kind: K_NONE, n_addr: 2'd0, n_dummy: 1'b0};
    case (op)
      8'h03:                             d = '{K_READ, 2'd3, 1'b0};
      8'h0B:                             d = '{K_READ, 2'd3, 1'b1};
      8'h05:                             d = '{K_STAT, 2'd0, 1'b0};
      8'h9F:                             d = '{K_ID,   2'd0, 1'b0};
      8'h3C:                             d = '{K_PROT, 2'd3, 1'b0};
      8'h02, 8'h20, 8'h52, 8'hD8,
      8'h36, 8'h39:                      d = '{K_PASS, 2'd3, 1'b0};
      8'h06, 8'h04, 8'h60, 8'hC7, 8'h01: d = '{K_PASS, 2'd0, 1'b0};
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d_i;
      else             stg[i] <= stg[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sfe_addr_ctr.sv
module sfe_addr_ctr #(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [7:0]    byte_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW+7:0] cat;
  assign cat = {addr_o, byte_i};

  // upper address bits fall off the top while shifting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (shift_i) addr_o <= cat[AW-1:0];
    else if (inc_i)   addr_o <= addr_o + 1'b1;
  end
endmodule

// File: rtl/sfe_cmd_front.sv
module sfe_cmd_front
  import sfe_pkg::*;
#(
  parameter int AW          = 20,
  parameter int SECTORS     = 16,
  parameter int ID_BYTES    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sck_i,
  input  logic                  si_i,
  input  logic                  hold_ni,
  output logic                  so_o,
  output logic                  so_oe_o,
  output logic [AW-1:0]         mem_addr_o,
  input  logic [7:0]            mem_data_i,
  input  logic [7:0]            status_i,
  input  logic [ID_BYTES*8-1:0] id_i,
  input  logic [SECTORS-1:0]    prot_i,
  output logic [7:0]            opcode_o,
  output logic [AW-1:0]         cmd_addr_o,
  output logic                  wr_vld_o,
  output logic [7:0]            wr_byte_o,
  output logic                  cmd_done_o
);
  localparam int SW  = $clog2(SECTORS);
  localparam int IDW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  logic [3:0] raw, syn;
  logic       cs_s, sck_s, si_s, hold_s;
  logic       sck_d, cs_d, hold_act;

  assign raw = {cs_ni, sck_i, si_i, hold_ni};

  sfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );
  assign {cs_s, sck_s, si_s, hold_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      hold_act <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      if (!hold_s && !sck_s) hold_act <= 1'b1;   // hold starts only with SCK low
      else if (hold_s)       hold_act <= 1'b0;
    end
  end

  logic sck_rise, sck_fall, cs_rise;
  assign sck_rise = !cs_s && !hold_act && sck_s && !sck_d;
  assign sck_fall = !cs_s && !hold_act && !sck_s && sck_d;
  assign cs_rise  = cs_s && !cs_d;

  // input parse
  logic [2:0] bit_cnt, bidx, hdr_len;
  logic [6:0] sreg;
  logic [7:0] new_byte;
  dec_t       dec_q, dec_n;
  logic       byte_done, in_data, addr_shift, ld_rd, out_kind, load_out;

  assign new_byte   = {sreg, si_s};
  assign dec_n      = decode(new_byte);
  assign byte_done  = sck_rise && (bit_cnt == 3'd7);
  assign in_data    = (dec_q.kind != K_NONE) && (bidx >= hdr_len);
  assign addr_shift = byte_done && (dec_q.kind != K_NONE) && (bidx != 3'd0) &&
                      (bidx <= {1'b0, dec_q.n_addr});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      bidx       <= '0;
      hdr_len    <= 3'd1;
      sreg       <= '0;
      dec_q      <= '{K_NONE, 2'd0, 1'b0};
      opcode_o   <= '0;
      wr_vld_o   <= 1'b0;
      wr_byte_o  <= '0;
      cmd_done_o <= 1'b0;
    end else begin
      wr_vld_o   <= 1'b0;
      cmd_done_o <= cs_rise && (dec_q.kind == K_PASS) && (bidx >= hdr_len) &&
                    (bit_cnt == 3'd0);
      if (cs_s) begin
        bit_cnt <= '0;
        bidx    <= '0;
        dec_q   <= '{K_NONE, 2'd0, 1'b0};
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        sreg    <= new_byte[6:0];
        if (byte_done) begin
          if (bidx != 3'd7) bidx <= bidx + 1'b1;
          if (bidx == 3'd0) begin
            dec_q    <= dec_n;
            opcode_o <= new_byte;
            hdr_len  <= 3'd1 + {1'b0, dec_n.n_addr} + {2'b0, dec_n.n_dummy};
          end
          if (in_data && dec_q.kind == K_PASS) begin
            wr_vld_o  <= 1'b1;
            wr_byte_o <= new_byte;
          end
        end
      end
    end
  end

  // output path
  logic [7:0]     nxt;
  logic [6:0]     osr;
  logic           so_q, drv_q;
  logic [IDW-1:0] id_idx;
  logic [SW-1:0]  sect;

  assign sect     = mem_addr_o[AW-1 -: SW];
  assign out_kind = in_data && (dec_q.kind != K_PASS);
  assign load_out = sck_fall && out_kind && (bit_cnt == 3'd0);
  assign ld_rd    = load_out && (dec_q.kind == K_READ);

  always_comb begin
    case (dec_q.kind)
      K_READ:  nxt = mem_data_i;
      K_STAT:  nxt = status_i;
      K_ID:    nxt = id_i[(ID_BYTES-1-int'(id_idx))*8 +: 8];
      K_PROT:  nxt = prot_i[sect] ? 8'hFF : 8'h00;
      default: nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_q   <= 1'b0;
      osr    <= '0;
      drv_q  <= 1'b0;
      id_idx <= '0;
    end else if (cs_s) begin
      drv_q  <= 1'b0;
      id_idx <= '0;
    end else if (sck_fall && out_kind) begin
      if (bit_cnt == 3'd0) begin
        so_q  <= nxt[7];
        osr   <= nxt[6:0];
        drv_q <= 1'b1;
        if (dec_q.kind == K_ID)
          id_idx <= (int'(id_idx) == ID_BYTES-1) ? '0 : id_idx + 1'b1;
      end else begin
        so_q <= osr[6];
        osr  <= {osr[5:0], 1'b0};
      end
    end
  end

  sfe_addr_ctr #(.AW(AW)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(addr_shift),
    .byte_i(new_byte), .inc_i(ld_rd), .addr_o(mem_addr_o)
  );

  assign cmd_addr_o = mem_addr_o;
  assign so_o       = so_q;
  assign so_oe_o    = drv_q && !cs_s && !hold_act;
endmodule

// File: rtl/sfe_cmd_front_chk.sv
module sfe_cmd_front_chk #(
  parameter int AW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          so_oe_o,
  input logic          wr_vld_o,
  input logic          cmd_done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          ld_rd_i,
  input logic          hold_act_i,
  input logic          cs_s_i,
  input logic [2:0]    bit_cnt_i
);
  logic [7:0] cs_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cs_hi_cnt <= '0;
    else if (!cs_ni)         cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 8'hFF) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  // R11
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cs_hi_cnt) > SYNC_STAGES) |-> !so_oe_o);

  // R8
  pass_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> !so_oe_o);

  // R8
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |=> !wr_vld_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o);

  // R4
  rd_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rd_i |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R12
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act_i && $past(hold_act_i) && !cs_s_i && $past(!cs_s_i)) |-> $stable(bit_cnt_i));
endmodule

bind sfe_cmd_front sfe_cmd_front_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .so_oe_o(so_oe_o),
  .wr_vld_o(wr_vld_o), .cmd_done_o(cmd_done_o), .mem_addr_o(mem_addr_o),
  .ld_rd_i(ld_rd), .hold_act_i(hold_act), .cs_s_i(cs_s), .bit_cnt_i(bit_cnt)
);

// File: tb/sfe_cmd_front_tb.sv
module sfe_cmd_front_tb;
  localparam int AW = 20;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, wr_vld, cmd_done;
  logic [AW-1:0] mem_addr, cmd_addr;
  logic [7:0] mem_data, opcode, wr_byte;
  logic [7:0] status = 8'hA5;
  logic [31:0] id = 32'hC27E913B;
  logic [15:0] prot = 16'h0008;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
  endfunction
  assign mem_data = mem_f(mem_addr);

  sfe_cmd_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .status_i(status), .id_i(id), .prot_i(prot),
    .opcode_o(opcode), .cmd_addr_o(cmd_addr), .wr_vld_o(wr_vld),
    .wr_byte_o(wr_byte), .cmd_done_o(cmd_done)
  );

  int n_chk = 0, n_bad = 0, n_wr = 0, n_done = 0;
  bit oe_seen = 0, done_flag = 0;

  typedef struct {logic [7:0] op; logic [AW-1:0] addr; bit use_a;} done_t;
  logic [7:0] exp_wr[$];
  done_t      exp_done[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (so_oe) oe_seen <= 1'b1;
    if (wr_vld) begin
      n_wr++;
      if (exp_wr.size() == 0) chk(0, "R8", "unexpected wr byte", {24'h0, wr_byte}, 0);
      else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        chk(wr_byte === e, "R8", "wr byte", {24'h0, wr_byte}, {24'h0, e});
      end
    end
    if (cmd_done) begin
      n_done++;
      if (exp_done.size() == 0) chk(0, "R9", "unexpected done", {24'h0, opcode}, 0);
      else begin
        done_t d;
        d = exp_done.pop_front();
        chk(opcode === d.op, "R9", "done opcode", {24'h0, opcode}, {24'h0, d.op});
        if (d.use_a) chk(cmd_addr === d.addr, "R9", "done addr", {12'h0, cmd_addr}, {12'h0, d.addr});
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_on(bit m3);
    sck = m3; tick(4); cs_n = 1'b0; oe_seen = 0; tick(HP);
  endtask

  task automatic frame_off(bit m3);
    if (!m3) begin sck = 1'b0; tick(HP); end
    cs_n = 1'b1; tick(10);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i]; tick(HP);
      rx[i] = so_oe ? so : 1'bx;
      sck = 1'b1; tick(HP);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx;
    xbyte(tx, rx);
  endtask

  task automatic rd_exp(string req, logic [7:0] e);
    logic [7:0] rx;
    xbyte(8'h00, rx);
    chk(rx === e, req, "read byte", {24'h0, rx}, {24'h0, e});
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w0, d0;
    logic [7:0] rx;
    tick(5);
    // R1
    chk(so_oe === 1'b0, "R1", "reset oe", {31'h0, so_oe}, 0);
    chk(wr_vld === 1'b0, "R1", "reset wr_vld", {31'h0, wr_vld}, 0);
    chk(cmd_done === 1'b0, "R1", "reset done", {31'h0, cmd_done}, 0);
    rst_n = 1'b1; tick(5);

    // R2 plain read
    frame_on(0); send(8'h03); send_addr(24'h012345);
    for (int k = 0; k < 4; k++) rd_exp("R2", mem_f(20'h12345 + 20'(k)));
    frame_off(0);
    // R11 idle after frame
    chk(so_oe === 1'b0, "R11", "oe after cs high", {31'h0, so_oe}, 0);

    // R3 read with dummy
    frame_on(0); send(8'h0B); send_addr(24'h0ABCDE); send(8'hFF);
    for (int k = 0; k < 3; k++) rd_exp("R3", mem_f(20'hABCDE + 20'(k)));
    frame_off(0);

    // R4 wrap, upper nibble ignored
    frame_on(0); send(8'h03); send_addr(24'hFFFFFE);
    rd_exp("R4", mem_f(20'hFFFFE)); rd_exp("R4", mem_f(20'hFFFFF));
    rd_exp("R4", mem_f(20'h00000)); rd_exp("R4", mem_f(20'h00001));
    frame_off(0);

    // R5 status repeats
    frame_on(0); send(8'h05);
    for (int k = 0; k < 3; k++) rd_exp("R5", 8'hA5);
    frame_off(0);

    // R6 id bytes cycle
    frame_on(0); send(8'h9F);
    for (int k = 0; k < 6; k++) rd_exp("R6", id[(3 - (k % 4))*8 +: 8]);
    frame_off(0);

    // R7 protection readback
    frame_on(0); send(8'h3C); send_addr(24'h03F000);
    rd_exp("R7", 8'hFF); rd_exp("R7", 8'hFF);
    frame_off(0);
    frame_on(0); send(8'h3C); send_addr(24'h040000);
    rd_exp("R7", 8'h00);
    frame_off(0);

    // R8 R9 program with data
    exp_wr.push_back(8'h11); exp_wr.push_back(8'h22); exp_wr.push_back(8'h33);
    exp_done.push_back('{8'h02, 20'h000FE, 1'b1});
    frame_on(0); send(8'h02); send_addr(24'h0000FE);
    send(8'h11); send(8'h22); send(8'h33);
    chk(oe_seen == 0, "R8", "SO driven in write", {31'h0, oe_seen}, 0);
    frame_off(0);

    // R9 erase and no-address command
    exp_done.push_back('{8'hD8, 20'h50000, 1'b1});
    frame_on(0); send(8'hD8); send_addr(24'h050000); frame_off(0);
    exp_done.push_back('{8'h06, 20'h0, 1'b0});
    frame_on(0); send(8'h06); frame_off(0);

    // R9 truncated header and misaligned end
    d0 = n_done;
    frame_on(0); send(8'h20); send(8'h01); send(8'h02); frame_off(0);
    exp_wr.push_back(8'h44);
    frame_on(0); send(8'h02); send_addr(24'h000010); send(8'h44);
    xbits(8'hE0, 3, rx); frame_off(0);
    chk(n_done == d0, "R9", "done on truncated", n_done, d0);

    // R10 unknown opcode
    w0 = n_wr; d0 = n_done;
    frame_on(0); send(8'hAB); send(8'h02); send_addr(24'h000100); send(8'h55);
    chk(oe_seen == 0, "R10", "SO driven on unknown", {31'h0, oe_seen}, 0);
    frame_off(0);
    chk(n_wr == w0, "R10", "wr on unknown", n_wr, w0);
    chk(n_done == d0, "R10", "done on unknown", n_done, d0);

    // R12 hold during read
    frame_on(0); send(8'h03); send_addr(24'h000100);
    rd_exp("R12", mem_f(20'h00100));
    sck = 1'b0; tick(HP);
    hold_n = 1'b0; tick(HP);
    chk(so_oe === 1'b0, "R11", "oe during hold", {31'h0, so_oe}, 0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; si = k[0]; tick(HP); sck = 1'b0; tick(HP);
    end
    hold_n = 1'b1; tick(HP);
    rd_exp("R12", mem_f(20'h00101)); rd_exp("R12", mem_f(20'h00102));
    frame_off(0);

    // R13 mode 3
    frame_on(1); send(8'h0B); send_addr(24'h0F00F0); send(8'h00);
    for (int k = 0; k < 3; k++) rd_exp("R13", mem_f(20'hF00F0 + 20'(k)));
    frame_off(1);
    sck = 1'b0; tick(10);

    chk(exp_wr.size() == 0, "R8", "missing wr bytes", exp_wr.size(), 0);
    chk(exp_done.size() == 0, "R9", "missing done", exp_done.size(), 0);
    summary();
  end
endmodule